// File: doc/BRIEF.md
# Exposure Flush and Transfer Sequencer

This block produces the three vertical transfer clocks of a frame-transfer CCD: the image-area gate clock, the storage-area gate clock and the transfer-gate clock. It does not generate line timing. Instead, a horizontal-rate clock-enable tick comes in from outside, and each burst emits one pulse per tick. A pulse is one clock cycle wide and appears in the cycle right after the tick is sampled.

Exposure is controlled by a parallel-transfer gate signal. A select input decides where that gate comes from: either the vertical-drive input (fixed integration time) or an external gate input driven by user logic (variable integration time). While the gate stays high, charge integrates and no pulses are made. A falling gate edge starts a counted burst, and the level of vertical drive at that edge picks the burst type:
- With vertical drive high, the burst is a flush burst that starts at once.
- With vertical drive low, the burst is a readout burst that waits until vertical drive is high again.

A long refresh burst runs when reset is released and whenever standby is released. A low standby input stops everything and holds the clocks low. A busy output marks an accepted burst from its trigger to its last pulse.

Top module: `exposure_sequencer`

## Requirements
- R1: With `gate_sel` high, the gate is `vdrive` and `gate_ext` has no effect. With `gate_sel` low, the gate is `gate_ext` and `vdrive` edges alone start nothing.
- R2: A gate falling edge sampled while `vdrive` is high, with the block idle, produces exactly 302 pulses on each of `img_clk`, `stor_clk` and `xfer_clk`.
- R3: A gate falling edge sampled while `vdrive` is low, with the block idle, produces no pulses while `vdrive` stays low. Once `vdrive` is high, it produces exactly 290 pulses on each output.
- R4: While the gate stays high, no pulse is produced on any output.
- R5: After reset release, and after every rising edge of `standby_n`, a refresh burst of exactly 1026 pulses runs on each output. The gate and `vdrive` do not need to be involved.
- R6: While `standby_n` is low, all three clock outputs and `busy` are low, and any running burst is abandoned.
- R7: Two gate low pulses in sequence, each arriving while idle with `vdrive` high, produce two separate bursts of 302 pulses each.
- R8: A gate falling edge that arrives while a burst is pending or running is ignored. The running burst keeps its original length.
- R9: `busy` is low during reset and when idle. It is high from the cycle after a burst is accepted until the last pulse of that burst, and every output pulse falls while `busy` is high.
- R10: Each output pulse is high for one clock cycle. It begins in the cycle after a clock edge that sampled `line_tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | Horizontal-rate clock enable, one pulse per burst step |
| vdrive | input | 1 | Vertical-drive level |
| gate_ext | input | 1 | External parallel-transfer gate |
| gate_sel | input | 1 | 1: gate taken from vdrive, 0: gate taken from gate_ext |
| standby_n | input | 1 | Active-low standby |
| img_clk | output | 1 | Image-area gate clock pulses |
| stor_clk | output | 1 | Storage-area gate clock pulses |
| xfer_clk | output | 1 | Transfer-gate clock pulses |
| busy | output | 1 | High while a burst is pending or running |

## Verification
The burst length lives in a down-counter, so a wrong load value or a skipped decrement only shows up as a pulse count that is off. That error becomes visible at the end of the burst, a few thousand cycles after the trigger. For this reason every burst is counted in full on all three outputs. A controller stuck in its waiting or running state shows at once as `busy` failing to drop, or as pulses appearing while `vdrive` is still low. A lane that ignores standby shows in the first cycle after `standby_n` falls.

// File: rtl/exp_seq_pkg.sv
package exp_seq_pkg;

   typedef enum logic [1:0] {
      SQ_HALT = 2'd0,
      SQ_IDLE = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_RUN  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      BK_NONE    = 2'd0,
      BK_FLUSH   = 2'd1,
      BK_READ    = 2'd2,
      BK_REFRESH = 2'd3
   } burst_kind_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/gate_front.sv
module gate_front #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vdrive,
   input  logic gate_ext,
   input  logic gate_sel,
   output logic gate_fall
);
   logic gate_now;
   logic gate_q;

   assign gate_now = gate_sel ? vdrive : gate_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) gate_q <= IDLE_LEVEL;
      else        gate_q <= gate_now;
   end

   assign gate_fall = gate_q & ~gate_now;

   a_r1_fall_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
      gate_fall |-> (gate_sel ? !vdrive : !gate_ext));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import exp_seq_pkg::*;
#(
   parameter int FLUSH_LEN   = 302,
   parameter int READ_LEN    = 290,
   parameter int REFRESH_LEN = 1026,
   localparam int MAX_LEN    = max3(FLUSH_LEN, READ_LEN, REFRESH_LEN),
   localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        standby_n,
   input  logic        line_tick,
   input  logic        vdrive,
   input  logic        gate_fall,
   output logic        fire,
   output burst_kind_t kind,
   output logic        core_busy
);
   seq_state_t       state;
   logic [CNT_W-1:0] remain;
   logic             last_step;

   assign last_step = (remain == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SQ_HALT;
         remain <= '0;
         kind   <= BK_NONE;
      end else if (!standby_n) begin
         state  <= SQ_HALT;
         remain <= '0;
         kind   <= BK_NONE;
      end else begin
         unique case (state)
            SQ_HALT: begin
               state  <= SQ_RUN;
               remain <= CNT_W'(REFRESH_LEN);
               kind   <= BK_REFRESH;
            end
            SQ_IDLE: begin
               if (gate_fall) begin
                  if (vdrive) begin
                     state  <= SQ_RUN;
                     remain <= CNT_W'(FLUSH_LEN);
                     kind   <= BK_FLUSH;
                  end else begin
                     state  <= SQ_WAIT;
                     kind   <= BK_READ;
                  end
               end
            end
            SQ_WAIT: begin
               if (vdrive) begin
                  state  <= SQ_RUN;
                  remain <= CNT_W'(READ_LEN);
               end
            end
            SQ_RUN: begin
               if (line_tick) begin
                  if (last_step) begin
                     state  <= SQ_IDLE;
                     remain <= '0;
                     kind   <= BK_NONE;
                  end else begin
                     remain <= remain - CNT_W'(1);
                  end
               end
            end
            default: state <= SQ_HALT;
         endcase
      end
   end

   assign fire      = (state == SQ_RUN) & line_tick & standby_n;
   assign core_busy = (state == SQ_RUN) | (state == SQ_WAIT);

   a_r9_run_has_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_RUN) |-> (remain != '0));
   a_r2_flush_load: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && gate_fall && vdrive && standby_n)
      |=> (state == SQ_RUN && remain == CNT_W'(FLUSH_LEN)));
   a_r3_wait_for_vd: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WAIT && !vdrive && standby_n) |=> (state == SQ_WAIT));
   a_r8_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_RUN && gate_fall && standby_n && !(line_tick && last_step))
      |=> (state == SQ_RUN));
   a_r5_refresh_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HALT && standby_n)
      |=> (state == SQ_RUN && remain == CNT_W'(REFRESH_LEN) && kind == BK_REFRESH));
endmodule

// File: rtl/lane_drv.sv
module lane_drv
   import exp_seq_pkg::*;
#(
   parameter int               N_LANES      = 3,
   parameter logic [N_LANES-1:0] XFER_MASK    = '1,
   parameter logic [N_LANES-1:0] REFRESH_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               standby_n,
   input  logic               fire,
   input  burst_kind_t        kind,
   output logic [N_LANES-1:0] lane_out
);
   logic [N_LANES-1:0] sel_mask;

   assign sel_mask = (kind == BK_REFRESH) ? REFRESH_MASK : XFER_MASK;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (!rst_n || !standby_n) pulse_q <= 1'b0;
         else                      pulse_q <= fire & sel_mask[i];
      end
      assign lane_out[i] = pulse_q & standby_n;

      a_r6_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !standby_n |=> !pulse_q);
   end
endmodule

// File: rtl/exposure_sequencer.sv
module exposure_sequencer
   import exp_seq_pkg::*;
#(
   parameter int FLUSH_LEN   = 302,
   parameter int READ_LEN    = 290,
   parameter int REFRESH_LEN = 1026
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_tick,
   input  logic vdrive,
   input  logic gate_ext,
   input  logic gate_sel,
   input  logic standby_n,
   output logic img_clk,
   output logic stor_clk,
   output logic xfer_clk,
   output logic busy
);
   localparam int N_LANES = 3;

   if (FLUSH_LEN < 1 || READ_LEN < 1 || REFRESH_LEN < 1) begin : g_bad_len
      $error("burst lengths must be at least one");
   end

   logic              gate_fall;
   logic              fire;
   logic              core_busy;
   burst_kind_t       kind;
   logic [N_LANES-1:0] lanes;

   gate_front #(.IDLE_LEVEL(1'b1)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .vdrive    (vdrive),
      .gate_ext  (gate_ext),
      .gate_sel  (gate_sel),
      .gate_fall (gate_fall)
   );

   seq_ctrl #(
      .FLUSH_LEN   (FLUSH_LEN),
      .READ_LEN    (READ_LEN),
      .REFRESH_LEN (REFRESH_LEN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_n (standby_n),
      .line_tick (line_tick),
      .vdrive    (vdrive),
      .gate_fall (gate_fall),
      .fire      (fire),
      .kind      (kind),
      .core_busy (core_busy)
   );

   lane_drv #(
      .N_LANES      (N_LANES),
      .XFER_MASK    (3'b111),
      .REFRESH_MASK (3'b111)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_n (standby_n),
      .fire      (fire),
      .kind      (kind),
      .lane_out  (lanes)
   );

   assign img_clk  = lanes[0];
   assign stor_clk = lanes[1];
   assign xfer_clk = lanes[2];
   assign busy     = (core_busy | (|lanes)) & standby_n;

   a_r10_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      img_clk |-> $past(line_tick));
   a_r6_busy_off_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_n |-> !busy);
endmodule

// File: tb/tb_exposure_sequencer.sv
module tb_exposure_sequencer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_tick = 1'b0;
   logic vdrive = 1'b1;
   logic gate_ext = 1'b1;
   logic gate_sel = 1'b0;
   logic standby_n = 1'b1;
   logic img_clk, stor_clk, xfer_clk, busy;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   int n_img = 0, n_stor = 0, n_xfer = 0;
   int bad_busy = 0, bad_stby = 0, bad_tick = 0, bad_width = 0;
   logic p_img = 1'b0, p_stor = 1'b0, p_xfer = 1'b0;
   logic tick_seen = 1'b0;

   always #5 clk = ~clk;

   exposure_sequencer dut (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vdrive(vdrive),
      .gate_ext(gate_ext), .gate_sel(gate_sel), .standby_n(standby_n),
      .img_clk(img_clk), .stor_clk(stor_clk), .xfer_clk(xfer_clk), .busy(busy)
   );

   // horizontal-rate tick: one cycle in four
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         line_tick <= (ph == 0);
         ph = (ph + 1) % 4;
      end
   end

   always @(posedge clk) tick_seen <= line_tick;

   always @(negedge clk) begin
      if (img_clk && !p_img) begin
         n_img++;
         if (!tick_seen) bad_tick++;
      end
      if (stor_clk && !p_stor) n_stor++;
      if (xfer_clk && !p_xfer) n_xfer++;
      if (img_clk && p_img) bad_width++;
      if ((img_clk || stor_clk || xfer_clk) && !busy) bad_busy++;
      if ((img_clk || stor_clk || xfer_clk || busy) && !standby_n) bad_stby++;
      p_img = img_clk; p_stor = stor_clk; p_xfer = xfer_clk;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_img = 0; n_stor = 0; n_xfer = 0;
      bad_busy = 0; bad_stby = 0; bad_tick = 0; bad_width = 0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      repeat (4) @(negedge clk);
      while (busy && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_counts(input string req, input int exp);
      check(n_img == exp,  {req, " img_clk count"},  n_img,  exp);
      check(n_stor == exp, {req, " stor_clk count"}, n_stor, exp);
      check(n_xfer == exp, {req, " xfer_clk count"}, n_xfer, exp);
   endtask

   task automatic ext_low_pulse();
      gate_ext <= 1'b0;
      repeat (3) @(negedge clk);
      gate_ext <= 1'b1;
   endtask

   task automatic t_reset_refresh();
      repeat (5) @(negedge clk);
      check({img_clk, stor_clk, xfer_clk, busy} == 4'b0, "R9 reset outputs",
            {img_clk, stor_clk, xfer_clk, busy}, 0);
      clear_mon();
      rst_n <= 1'b1;
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R9 busy after reset release", busy, 1);
      wait_idle();
      check_counts("R5 power-up refresh", 1026);
      check(bad_busy == 0, "R9 pulse outside busy", bad_busy, 0);
      check(bad_tick == 0, "R10 pulse without tick", bad_tick, 0);
      check(bad_width == 0, "R10 pulse width", bad_width, 0);
      check(busy == 1'b0, "R9 idle after refresh", busy, 0);
   endtask

   task automatic t_integrate();
      clear_mon();
      gate_sel <= 1'b0;
      gate_ext <= 1'b1;
      vdrive <= 1'b0;
      repeat (20) @(negedge clk);
      vdrive <= 1'b1;
      repeat (300) @(negedge clk);
      check(n_img == 0, "R4 no pulses while gate high", n_img, 0);
      check(busy == 1'b0, "R1 vdrive ignored with external gate", busy, 0);
   endtask

   task automatic t_flush_pair();
      clear_mon();
      vdrive <= 1'b1;
      ext_low_pulse();
      wait_idle();
      check_counts("R2 flush burst", 302);
      clear_mon();
      ext_low_pulse();
      wait_idle();
      check_counts("R7 second flush burst", 302);
      check(bad_busy == 0, "R9 flush pulses under busy", bad_busy, 0);
   endtask

   task automatic t_readout();
      clear_mon();
      vdrive <= 1'b0;
      repeat (5) @(negedge clk);
      ext_low_pulse();
      repeat (200) @(negedge clk);
      check(n_img == 0, "R3 no pulses while vdrive low", n_img, 0);
      check(busy == 1'b1, "R9 busy while readout pending", busy, 1);
      vdrive <= 1'b1;
      wait_idle();
      check_counts("R3 readout burst", 290);
   endtask

   task automatic t_vd_select();
      clear_mon();
      gate_sel <= 1'b1;
      vdrive <= 1'b1;
      repeat (3) @(negedge clk);
      ext_low_pulse();
      repeat (100) @(negedge clk);
      check(n_img == 0 && busy == 1'b0, "R1 gate_ext ignored when vdrive selected", n_img, 0);
      vdrive <= 1'b0;
      repeat (10) @(negedge clk);
      check(busy == 1'b1 && n_img == 0, "R1 vdrive fall accepted as gate", busy, 1);
      vdrive <= 1'b1;
      wait_idle();
      check_counts("R1 vdrive-gated readout", 290);
      gate_sel <= 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_overlap();
      clear_mon();
      vdrive <= 1'b1;
      ext_low_pulse();
      repeat (100) @(negedge clk);
      ext_low_pulse();
      repeat (100) @(negedge clk);
      ext_low_pulse();
      wait_idle();
      check_counts("R8 fall during burst ignored", 302);
   endtask

   task automatic t_standby();
      clear_mon();
      vdrive <= 1'b1;
      ext_low_pulse();
      repeat (100) @(negedge clk);
      standby_n <= 1'b0;
      @(negedge clk);
      clear_mon();
      repeat (60) @(negedge clk);
      check(n_img == 0 && n_stor == 0 && n_xfer == 0, "R6 clocks low in standby",
            n_img + n_stor + n_xfer, 0);
      check(bad_stby == 0, "R6 any output high in standby", bad_stby, 0);
      check(busy == 1'b0, "R6 busy low in standby", busy, 0);
      standby_n <= 1'b1;
      wait_idle();
      check_counts("R5 refresh after standby release", 1026);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000 && !done) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      t_reset_refresh();
      t_integrate();
      t_flush_pair();
      t_readout();
      t_vd_select();
      t_overlap();
      t_standby();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule